// File: doc/BRIEF.md
# Per-core hardware transaction state unit

This block keeps the transactional state of one processor core and the four special transaction registers that software can read only through a dedicated move-from-transaction instruction. The pipeline presents decoded begin, commit and explicit-abort commands with their operands and the current stack pointer. The memory side presents single-cycle capacity-overflow and contention pulses. The block tells the pipeline whether a transaction is open. When a transaction is aborted, it raises a one-cycle redirect that carries the handler address saved at begin.

The controller is a three-state machine. ST_IDLE means no transaction is open. ST_ACTIVE means a transaction is open. ST_ABORT is the single redirect cycle after an abort. The transitions are:

- IDLE to ACTIVE on a begin.
- ACTIVE to IDLE on a commit when no abort trigger is present.
- ACTIVE to ABORT on an overflow, contention or explicit-abort trigger.
- ABORT to IDLE unconditionally.

Every other input combination keeps the current state.

Top module: `txn_state_unit`

## Requirements
- R1: After reset, in_txn and redirect_valid are 0 and all four registers read 0.
- R2: A begin in ST_IDLE sets in_txn on the next cycle, loads register 0 with begin_handler and register 1 with cur_sp, clears register 2 to 0 (none), and leaves register 3 unchanged.
- R3: While a transaction is open, another begin is ignored: in_txn stays 1 and registers 0 and 1 keep their values.
- R4: rd_data is combinational on rd_sel (0 to 3 selects register 0 to 3). Register 2 sits in bits [1:0] and register 3 in bits [19:0], with the upper bits zero.
- R5: The cause codes are 0 none, 1 overflow, 2 contention and 3 explicit. When several triggers arrive in the same cycle, the cause recorded is the highest by priority: overflow, then contention, then explicit abort, then commit.
- R6: The cycle after an abort trigger in ST_ACTIVE, in_txn is 0 and redirect_valid is 1 for exactly one cycle with redirect_addr equal to register 0. redirect_addr is 0 whenever redirect_valid is 0.
- R7: Register 3 takes abort_code only when the explicit-abort cause is recorded. Overflow and contention aborts leave it unchanged.
- R8: A commit in ST_ACTIVE with no abort trigger clears in_txn on the next cycle without a redirect, and leaves registers 2 and 3 unchanged.
- R9: In ST_IDLE, commit, explicit-abort, overflow and contention inputs are ignored: no state change and no register change.
- R10: All inputs are ignored during the redirect cycle, including a begin. The unit then returns to ST_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_begin | input | 1 | Decoded begin command |
| begin_handler | input | DW | Abort handler address operand of begin |
| cur_sp | input | DW | Current stack pointer |
| cmd_commit | input | 1 | Decoded commit command |
| cmd_abort | input | 1 | Decoded explicit-abort command |
| abort_code | input | CODE_W | Software abort code operand |
| mem_overflow | input | 1 | Capacity overflow pulse from memory side |
| mem_conflict | input | 1 | Contention pulse from memory side |
| rd_sel | input | 2 | Special register index for the move instruction |
| rd_data | output | DW | Selected special register value |
| in_txn | output | 1 | Transaction open flag |
| redirect_valid | output | 1 | One-cycle abort redirect request |
| redirect_addr | output | DW | Redirect target (register 0) |

## Verification
The bound checker checks the control sequencing on every cycle:

- entry into a transaction on a begin;
- staying open while no trigger arrives;
- the exit to a single redirect cycle on any trigger;
- a clean exit on commit;
- idle inputs having no effect;
- redirect_addr being quiet outside the redirect cycle.

Only the bench scenarios can show the register contents. These are the captured handler and stack pointer, the cause chosen under simultaneous triggers, register 3 being updated only on explicit aborts, and the values preserved across ignored begins and idle triggers. The bench reads all of these back through the move-instruction port.

// File: rtl/txn_pkg.sv
package txn_pkg;

    localparam int NUM_TREGS = 4;
    localparam int SEL_W     = $clog2(NUM_TREGS);

    typedef enum logic [1:0] {
        CAUSE_NONE     = 2'd0,
        CAUSE_OVERFLOW = 2'd1,
        CAUSE_CONFLICT = 2'd2,
        CAUSE_EXPLICIT = 2'd3
    } cause_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_ABORT  = 2'd2
    } txn_state_e;

endpackage

// File: rtl/txn_fsm.sv
module txn_fsm
    import txn_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_begin,
    input  logic       cmd_commit,
    input  logic       cmd_abort,
    input  logic       mem_overflow,
    input  logic       mem_conflict,
    output txn_state_e state,
    output logic       do_begin,
    output logic       do_abort,
    output cause_e     abort_cause
);

    txn_state_e state_q;
    txn_state_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and decoded actions
    always_comb begin
        state_d     = state_q;
        do_begin    = 1'b0;
        do_abort    = 1'b0;
        abort_cause = CAUSE_NONE;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_begin) begin
                    state_d  = ST_ACTIVE;
                    do_begin = 1'b1;
                end
            end
            ST_ACTIVE: begin
                if (mem_overflow) begin
                    state_d     = ST_ABORT;
                    do_abort    = 1'b1;
                    abort_cause = CAUSE_OVERFLOW;
                end else if (mem_conflict) begin
                    state_d     = ST_ABORT;
                    do_abort    = 1'b1;
                    abort_cause = CAUSE_CONFLICT;
                end else if (cmd_abort) begin
                    state_d     = ST_ABORT;
                    do_abort    = 1'b1;
                    abort_cause = CAUSE_EXPLICIT;
                end else if (cmd_commit) begin
                    state_d = ST_IDLE;
                end
            end
            ST_ABORT: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/txn_regfile.sv
module txn_regfile
    import txn_pkg::*;
#(
    parameter int DW     = 32,
    parameter int CODE_W = 20
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          do_begin,
    input  logic [DW-1:0]                 begin_handler,
    input  logic [DW-1:0]                 cur_sp,
    input  logic                          do_abort,
    input  cause_e                        abort_cause,
    input  logic [CODE_W-1:0]             abort_code,
    output logic [NUM_TREGS-1:0][DW-1:0]  tregs
);

    localparam int CAUSE_PAD = DW - 2;
    localparam int CODE_PAD  = DW - CODE_W;

    logic [DW-1:0]     handler_q;
    logic [DW-1:0]     sp_q;
    cause_e            cause_q;
    logic [CODE_W-1:0] code_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            handler_q <= '0;
            sp_q      <= '0;
            cause_q   <= CAUSE_NONE;
            code_q    <= '0;
        end else begin
            if (do_begin) begin
                handler_q <= begin_handler;
                sp_q      <= cur_sp;
                cause_q   <= CAUSE_NONE;
            end
            if (do_abort) begin
                cause_q <= abort_cause;
                if (abort_cause == CAUSE_EXPLICIT) begin
                    code_q <= abort_code;
                end
            end
        end
    end

    assign tregs[0] = handler_q;
    assign tregs[1] = sp_q;
    assign tregs[2] = {{CAUSE_PAD{1'b0}}, cause_q};
    assign tregs[3] = {{CODE_PAD{1'b0}}, code_q};

endmodule

// File: rtl/txn_read_mux.sv
module txn_read_mux
    import txn_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [NUM_TREGS-1:0][DW-1:0] tregs,
    input  logic [SEL_W-1:0]             rd_sel,
    output logic [DW-1:0]                rd_data
);

    logic [NUM_TREGS-1:0][DW-1:0] masked;

    for (genvar g = 0; g < NUM_TREGS; g++) begin : g_term
        assign masked[g] = (rd_sel == SEL_W'(g)) ? tregs[g] : '0;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_TREGS; i++) begin
            rd_data = rd_data | masked[i];
        end
    end

endmodule

// File: rtl/txn_state_unit.sv
module txn_state_unit
    import txn_pkg::*;
#(
    parameter int DW     = 32,
    parameter int CODE_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_begin,
    input  logic [DW-1:0]     begin_handler,
    input  logic [DW-1:0]     cur_sp,
    input  logic              cmd_commit,
    input  logic              cmd_abort,
    input  logic [CODE_W-1:0] abort_code,
    input  logic              mem_overflow,
    input  logic              mem_conflict,
    input  logic [1:0]        rd_sel,
    output logic [DW-1:0]     rd_data,
    output logic              in_txn,
    output logic              redirect_valid,
    output logic [DW-1:0]     redirect_addr
);

    txn_state_e                   state;
    logic                         do_begin;
    logic                         do_abort;
    cause_e                       abort_cause;
    logic [NUM_TREGS-1:0][DW-1:0] tregs;

    txn_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_begin    (cmd_begin),
        .cmd_commit   (cmd_commit),
        .cmd_abort    (cmd_abort),
        .mem_overflow (mem_overflow),
        .mem_conflict (mem_conflict),
        .state        (state),
        .do_begin     (do_begin),
        .do_abort     (do_abort),
        .abort_cause  (abort_cause)
    );

    txn_regfile #(.DW(DW), .CODE_W(CODE_W)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .do_begin      (do_begin),
        .begin_handler (begin_handler),
        .cur_sp        (cur_sp),
        .do_abort      (do_abort),
        .abort_cause   (abort_cause),
        .abort_code    (abort_code),
        .tregs         (tregs)
    );

    txn_read_mux #(.DW(DW)) u_rd (
        .tregs   (tregs),
        .rd_sel  (rd_sel),
        .rd_data (rd_data)
    );

    // state-decoded outputs
    always_comb begin
        in_txn         = 1'b0;
        redirect_valid = 1'b0;
        redirect_addr  = '0;
        unique case (state)
            ST_IDLE: begin
            end
            ST_ACTIVE: begin
                in_txn = 1'b1;
            end
            ST_ABORT: begin
                redirect_valid = 1'b1;
                redirect_addr  = tregs[0];
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/txn_state_checker.sv
module txn_state_checker #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_begin,
    input logic          cmd_commit,
    input logic          cmd_abort,
    input logic          mem_overflow,
    input logic          mem_conflict,
    input logic          in_txn,
    input logic          redirect_valid,
    input logic [DW-1:0] redirect_addr
);

    logic trig;
    assign trig = mem_overflow | mem_conflict | cmd_abort;

    // R2: begin while idle opens a transaction
    a_r2_begin_enters: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_txn && !redirect_valid && cmd_begin) |=> in_txn);

    // R3: open transaction stays open without trigger or commit
    a_r3_stay_active: assert property (@(posedge clk) disable iff (!rst_n)
        (in_txn && !trig && !cmd_commit) |=> (in_txn && !redirect_valid));

    // R6: any trigger while open leads to the redirect cycle
    a_r6_abort_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        (in_txn && trig) |=> (redirect_valid && !in_txn));

    // R6: address quiet outside redirect
    a_r6_addr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect_valid |-> (redirect_addr == '0));

    // R8: clean commit closes without redirect
    a_r8_commit_exits: assert property (@(posedge clk) disable iff (!rst_n)
        (in_txn && !trig && cmd_commit) |=> (!in_txn && !redirect_valid));

    // R9: idle without begin stays idle
    a_r9_idle_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_txn && !redirect_valid && !cmd_begin) |=> (!in_txn && !redirect_valid));

    // R10: redirect lasts one cycle and returns to idle
    a_r10_redirect_returns: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> (!in_txn && !redirect_valid));

    // R6: flags never both high
    a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_txn && redirect_valid));

endmodule

bind txn_state_unit txn_state_checker #(.DW(DW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_begin      (cmd_begin),
    .cmd_commit     (cmd_commit),
    .cmd_abort      (cmd_abort),
    .mem_overflow   (mem_overflow),
    .mem_conflict   (mem_conflict),
    .in_txn         (in_txn),
    .redirect_valid (redirect_valid),
    .redirect_addr  (redirect_addr)
);

// File: tb/txn_state_unit_bench.sv
`timescale 1ns/1ps
module txn_state_unit_bench;

    localparam int DW     = 32;
    localparam int CODE_W = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_begin = 1'b0;
    logic [DW-1:0]     begin_handler = '0;
    logic [DW-1:0]     cur_sp = '0;
    logic              cmd_commit = 1'b0;
    logic              cmd_abort = 1'b0;
    logic [CODE_W-1:0] abort_code = '0;
    logic              mem_overflow = 1'b0;
    logic              mem_conflict = 1'b0;
    logic [1:0]        rd_sel = 2'd0;
    logic [DW-1:0]     rd_data;
    logic              in_txn;
    logic              redirect_valid;
    logic [DW-1:0]     redirect_addr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    txn_state_unit #(.DW(DW), .CODE_W(CODE_W)) u_txn_state_unit (
        .clk(clk), .rst_n(rst_n), .cmd_begin(cmd_begin), .begin_handler(begin_handler),
        .cur_sp(cur_sp), .cmd_commit(cmd_commit), .cmd_abort(cmd_abort),
        .abort_code(abort_code), .mem_overflow(mem_overflow), .mem_conflict(mem_conflict),
        .rd_sel(rd_sel), .rd_data(rd_data), .in_txn(in_txn),
        .redirect_valid(redirect_valid), .redirect_addr(redirect_addr)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_inputs();
        cmd_begin = 1'b0; cmd_commit = 1'b0; cmd_abort = 1'b0;
        mem_overflow = 1'b0; mem_conflict = 1'b0;
    endtask

    task automatic chk_reg(input string tag, input int idx, input logic [DW-1:0] exp);
        rd_sel = idx[1:0];
        #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic do_begin(input logic [DW-1:0] h, input logic [DW-1:0] sp);
        cmd_begin = 1'b1; begin_handler = h; cur_sp = sp;
        step();
        clear_inputs();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
        chk("R1 in_txn", {31'd0, in_txn}, 0);
        chk("R1 redirect_valid", {31'd0, redirect_valid}, 0);
        for (int i = 0; i < 4; i++) chk_reg("R1 reg after reset", i, 0);
    endtask

    task automatic t_begin_and_nest();
        do_begin(32'h0000_1000, 32'h0000_7FF0);
        chk("R2 in_txn after begin", {31'd0, in_txn}, 1);
        chk_reg("R2 R4 reg0 handler", 0, 32'h0000_1000);
        chk_reg("R2 R4 reg1 stack", 1, 32'h0000_7FF0);
        chk_reg("R2 reg2 none", 2, 0);
        do_begin(32'h0000_2222, 32'h0000_3333);
        chk("R3 in_txn after nested begin", {31'd0, in_txn}, 1);
        chk_reg("R3 reg0 kept", 0, 32'h0000_1000);
        chk_reg("R3 reg1 kept", 1, 32'h0000_7FF0);
    endtask

    task automatic t_explicit_abort();
        cmd_abort = 1'b1; abort_code = 20'hABCDE;
        step();
        clear_inputs();
        chk("R6 redirect_valid", {31'd0, redirect_valid}, 1);
        chk("R6 redirect_addr", redirect_addr, 32'h0000_1000);
        chk("R6 in_txn low", {31'd0, in_txn}, 0);
        chk_reg("R5 cause explicit", 2, 3);
        chk_reg("R7 code written", 3, 32'h000A_BCDE);
        step();
        chk("R6 redirect one cycle", {31'd0, redirect_valid}, 0);
        chk("R6 addr quiet", redirect_addr, 0);
    endtask

    task automatic t_overflow_abort();
        do_begin(32'h0000_4000, 32'h0000_6000);
        chk_reg("R2 begin clears cause", 2, 0);
        chk_reg("R2 begin keeps code", 3, 32'h000A_BCDE);
        mem_overflow = 1'b1;
        step();
        clear_inputs();
        chk("R6 overflow redirect addr", redirect_addr, 32'h0000_4000);
        chk_reg("R5 cause overflow", 2, 1);
        chk_reg("R7 code kept on overflow", 3, 32'h000A_BCDE);
        step();
    endtask

    task automatic t_priority_and_redirect_ignore();
        do_begin(32'h0000_5000, 32'h0000_5500);
        mem_conflict = 1'b1; cmd_abort = 1'b1; cmd_commit = 1'b1; abort_code = 20'h11111;
        step();
        clear_inputs();
        chk("R6 conflict redirect", {31'd0, redirect_valid}, 1);
        chk_reg("R5 contention beats explicit", 2, 2);
        chk_reg("R7 code kept on contention", 3, 32'h000A_BCDE);
        cmd_begin = 1'b1; begin_handler = 32'h0000_9999; cur_sp = 32'h0000_8888;
        step();
        clear_inputs();
        chk("R10 begin in redirect ignored", {31'd0, in_txn}, 0);
        chk_reg("R10 reg0 kept", 0, 32'h0000_5000);
    endtask

    task automatic t_idle_ignored();
        cmd_commit = 1'b1; cmd_abort = 1'b1; mem_overflow = 1'b1; mem_conflict = 1'b1;
        abort_code = 20'h22222;
        step();
        clear_inputs();
        chk("R9 in_txn idle", {31'd0, in_txn}, 0);
        chk("R9 no redirect idle", {31'd0, redirect_valid}, 0);
        chk_reg("R9 cause kept", 2, 2);
        chk_reg("R9 code kept", 3, 32'h000A_BCDE);
    endtask

    task automatic t_overflow_beats_explicit();
        do_begin(32'h0000_6100, 32'h0000_6200);
        mem_overflow = 1'b1; cmd_abort = 1'b1; abort_code = 20'h54321;
        step();
        clear_inputs();
        chk_reg("R5 overflow beats explicit", 2, 1);
        chk_reg("R7 code not written", 3, 32'h000A_BCDE);
        step();
    endtask

    task automatic t_commit();
        do_begin(32'h0000_7100, 32'h0000_7200);
        cmd_abort = 1'b1; abort_code = 20'h00777;
        step();
        clear_inputs();
        step();
        do_begin(32'h0000_7300, 32'h0000_7400);
        cmd_commit = 1'b1;
        step();
        clear_inputs();
        chk("R8 in_txn cleared", {31'd0, in_txn}, 0);
        chk("R8 no redirect", {31'd0, redirect_valid}, 0);
        chk_reg("R8 cause unchanged", 2, 0);
        chk_reg("R8 code unchanged", 3, 32'h0000_0777);
        step();
        chk("R8 still idle", {31'd0, in_txn | redirect_valid}, 0);
    endtask

    initial begin
        t_reset();
        t_begin_and_nest();
        t_explicit_abort();
        t_overflow_abort();
        t_priority_and_redirect_ignore();
        t_idle_ignored();
        t_overflow_beats_explicit();
        t_commit();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule